// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Incrementing Pointer

This block is the serial front end of a small register space of 64 bytes. The lowest eight addresses hold clock and control registers, and the rest are general-purpose RAM. The storage itself sits outside the block. The block recognises bus START and STOP conditions on the two-wire bus, compares the 7-bit device address, and takes a word address into a 6-bit pointer. It then moves data bytes in either direction and steps the pointer after each acknowledged byte. The block pulls SDA low through an open-drain enable. It reaches the storage through a simple port: an address, a one-cycle write strobe with its data, and a read-data input that follows the address combinationally.

SCL and SDA are first brought into the system clock domain through a two-stage synchronizer. Edge detection then runs on the synchronized copies. A power-fail input aborts any transfer, returns the pointer to zero and blinds the block to the bus for as long as it is held.

Top module: `twi_regslave`

## Requirements
- R1: After reset, SDA is released (`sda_drive_low`=0), no write strobe is issued and `reg_addr` is 0.
- R2: A START (SDA falling while SCL is high) begins address reception in any state. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. Bytes clocked after a STOP and before the next START are neither acknowledged nor written.
- R3: An address byte is sent MSB first. If its upper seven bits equal 1101000, the block acknowledges it by holding SDA low during the ninth clock. Bit 0 selects the direction: 0 for write (byte D0h), 1 for read (byte D1h).
- R4: An address byte with any other upper seven bits is not acknowledged. SDA stays released and no byte is acknowledged or written until the next START.
- R5: In a write, the first byte after the address loads its low six bits into the pointer. Each later byte is written to the location the pointer names. The block acknowledges every byte of a write.
- R6: The pointer steps by one after each acknowledged data byte, in writes and in reads. It wraps from 63 to 0.
- R7: In a read, the block sends the byte at the pointer MSB first and releases SDA for the master's acknowledge clock. Only when the master acknowledges does it step the pointer and send the next byte.
- R8: After a master non-acknowledge, the block keeps SDA released for all following clocks until the next START, and the pointer is not stepped.
- R9: A read that is not preceded by a word address starts at the location left in the pointer by the previous transfer.
- R10: A repeated START issued without a STOP, for example after a word address, returns the block to address reception, so a read can follow directly.
- R11: While `pwr_fail` is high, the transfer in progress is abandoned, SDA is released, the pointer is forced to 0, and no bus activity is acknowledged or written. The next access after power returns starts at location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| pwr_fail | input | 1 | Supply out of tolerance; aborts and blinds the slave |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| reg_addr | output | 6 | Pointer, used as the storage address |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rdata | input | 8 | Byte stored at `reg_addr` |

## Verification
The bench reads back after a burst that wraps from 63 to 0. A design that stepped a 6-bit counter without the wrap, or that stepped before the write landed, would put bytes at shifted locations. The bench also reads across a master non-acknowledge and then issues a current-address read. A design that stepped on every byte would return the following location, and one that kept driving would corrupt the extra clocks, which must read as FFh. A foreign address, bytes sent after a STOP, and bytes sent under power fail must all go unacknowledged and leave storage untouched. The current-address read after power fail must come from location 0, which exposes a pointer that was not cleared.

// File: rtl/twi_reg_pkg.sv
package twi_reg_pkg;

    localparam int unsigned SPACE_BYTES = 64;
    localparam int unsigned PTR_BITS    = $clog2(SPACE_BYTES);
    localparam int unsigned BYTE_BITS   = 8;
    localparam logic [6:0]  DEV_ID      = 7'b1101000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RLOAD,
        ST_RDAT,
        ST_RACK
    } slv_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_evt_t;

    function automatic logic [PTR_BITS-1:0] ptr_step(input logic [PTR_BITS-1:0] p);
        if (p == PTR_BITS'(SPACE_BYTES - 1))
            return '0;
        return p + 1'b1;
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst)
                chain <= '1;
            else
                chain <= {chain[STAGES-2:0], raw[i]};
        end
        assign synced[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect
    import twi_reg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);

    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        evt.start    = scl_p & scl_s & sda_p & ~sda_s;
        evt.stop     = scl_p & scl_s & ~sda_p & sda_s;
        evt.scl_rise = ~scl_p & scl_s;
        evt.scl_fall = scl_p & ~scl_s;
    end

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
    import twi_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = DEV_ID
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwr_fail,
    input  bus_evt_t             evt,
    input  logic                 scl_s,
    input  logic                 sda_s,
    input  logic [BYTE_BITS-1:0] rdata,
    output logic [PTR_BITS-1:0]  ptr_q,
    output logic                 wr_q,
    output logic [BYTE_BITS-1:0] wdata_q,
    output logic                 drive_q
);

    localparam int unsigned CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS - 1);

    slv_state_e           state;
    logic [CNT_W-1:0]     bitcnt;
    logic [BYTE_BITS-1:0] shreg;
    logic                 rd_dir;
    logic                 mst_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            rd_dir  <= 1'b0;
            mst_ack <= 1'b0;
            ptr_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            drive_q <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            if (pwr_fail) begin
                state   <= ST_IDLE;
                ptr_q   <= '0;
                drive_q <= 1'b0;
            end else if (evt.start) begin
                state   <= ST_DEV;
                bitcnt  <= '0;
                drive_q <= 1'b0;
            end else if (evt.stop) begin
                state   <= ST_IDLE;
                drive_q <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEV, ST_WORD, ST_WDAT: begin
                        if (evt.scl_rise && bitcnt < FULL) begin
                            shreg  <= {shreg[BYTE_BITS-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.scl_fall && bitcnt == FULL) begin
                            if (state == ST_DEV) begin
                                if (shreg[BYTE_BITS-1:1] == DEV_ADDR) begin
                                    rd_dir  <= shreg[0];
                                    drive_q <= 1'b1;
                                    state   <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_WORD) begin
                                ptr_q   <= shreg[PTR_BITS-1:0];
                                drive_q <= 1'b1;
                                state   <= ST_WORD_ACK;
                            end else begin
                                wr_q    <= 1'b1;
                                wdata_q <= shreg;
                                drive_q <= 1'b1;
                                state   <= ST_WDAT_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (evt.scl_fall) begin
                            drive_q <= 1'b0;
                            bitcnt  <= '0;
                            state   <= rd_dir ? ST_RLOAD : ST_WORD;
                        end
                    end
                    ST_WORD_ACK: begin
                        if (evt.scl_fall) begin
                            drive_q <= 1'b0;
                            bitcnt  <= '0;
                            state   <= ST_WDAT;
                        end
                    end
                    ST_WDAT_ACK: begin
                        if (evt.scl_fall) begin
                            drive_q <= 1'b0;
                            bitcnt  <= '0;
                            ptr_q   <= ptr_step(ptr_q);
                            state   <= ST_WDAT;
                        end
                    end
                    ST_RLOAD: begin
                        shreg   <= rdata;
                        drive_q <= ~rdata[BYTE_BITS-1];
                        bitcnt  <= '0;
                        state   <= ST_RDAT;
                    end
                    ST_RDAT: begin
                        if (evt.scl_fall) begin
                            if (bitcnt == LAST) begin
                                drive_q <= 1'b0;
                                state   <= ST_RACK;
                            end else begin
                                shreg   <= {shreg[BYTE_BITS-2:0], 1'b0};
                                drive_q <= ~shreg[BYTE_BITS-2];
                                bitcnt  <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise) begin
                            mst_ack <= ~sda_s;
                        end else if (evt.scl_fall) begin
                            if (mst_ack) begin
                                ptr_q <= ptr_step(ptr_q);
                                state <= ST_RLOAD;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !drive_q); // R2

    AST_PF_RELEASE: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> (!drive_q && ptr_q == '0)); // R11

    AST_PF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> !wr_q); // R11

    AST_WR_PTR_HOLD: assert property (@(posedge clk) disable iff (rst || pwr_fail)
        wr_q |=> $stable(ptr_q)); // R6

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_q) |-> !$past(scl_s)); // R7

endmodule

// File: rtl/twi_regslave.sv
module twi_regslave
    import twi_reg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [6:0]  DEV_ADDR    = DEV_ID
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic                 pwr_fail,
    output logic                 sda_drive_low,
    output logic [PTR_BITS-1:0]  reg_addr,
    output logic                 reg_wr,
    output logic [BYTE_BITS-1:0] reg_wdata,
    input  logic [BYTE_BITS-1:0] reg_rdata
);

    logic [1:0] lines_s;
    bus_evt_t   evt;

    twi_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    ({scl_in, sda_in}),
        .synced (lines_s)
    );

    twi_cond_detect u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .evt   (evt)
    );

    twi_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pwr_fail (pwr_fail),
        .evt      (evt),
        .scl_s    (lines_s[1]),
        .sda_s    (lines_s[0]),
        .rdata    (reg_rdata),
        .ptr_q    (reg_addr),
        .wr_q     (reg_wr),
        .wdata_q  (reg_wdata),
        .drive_q  (sda_drive_low)
    );

endmodule

// File: tb/twi_regslave_test.sv
module twi_regslave_test;

    localparam int H = 25;

    logic       clk = 1'b0;
    logic       rst;
    logic       scl_m, sda_m, pwr_fail;
    logic       sda_drive_low, reg_wr;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [64];
    logic [7:0] exp_mem [64];
    wire        sda_bus = sda_m & ~sda_drive_low;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    twi_regslave uut (
        .clk           (clk),
        .rst           (rst),
        .scl_in        (scl_m),
        .sda_in        (sda_bus),
        .pwr_fail      (pwr_fail),
        .sda_drive_low (sda_drive_low),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata)
    );

    function automatic logic [7:0] pattern(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= pattern(i);
        end else if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = mem[reg_addr];

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wcyc(H);
        scl_m = 1'b1; wcyc(H);
        sda_m = 1'b0; wcyc(H);
        scl_m = 1'b0; wcyc(3);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wcyc(H);
        scl_m = 1'b1; wcyc(H);
        sda_m = 1'b1; wcyc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wcyc(H);
            scl_m = 1'b1; wcyc(H);
            scl_m = 1'b0; wcyc(3);
        end
        sda_m = 1'b1; wcyc(H);
        scl_m = 1'b1; wcyc(H / 2);
        acked = ~sda_bus;
        wcyc(H - H / 2);
        scl_m = 1'b0; wcyc(3);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wcyc(H);
            scl_m = 1'b1; wcyc(H / 2);
            b[i] = sda_bus;
            wcyc(H - H / 2);
            scl_m = 1'b0; wcyc(3);
        end
        sda_m = ~give_ack; wcyc(H);
        scl_m = 1'b1; wcyc(H);
        scl_m = 1'b0; wcyc(3);
        sda_m = 1'b1;
    endtask

    task automatic set_word(input logic [7:0] a);
        logic k;
        bus_start();
        send_byte(8'hD0, k); chk("R3 write address ack", 8'(k), 8'd1);
        send_byte(a, k);     chk("R5 word address ack", 8'(k), 8'd1);
    endtask

    task automatic t_reset();
        chk("R1 sda released", 8'(sda_drive_low), 8'd0);
        chk("R1 no write", 8'(reg_wr), 8'd0);
        chk("R1 pointer zero", 8'(reg_addr), 8'd0);
    endtask

    task automatic t_write_burst();
        logic k;
        set_word(8'd5);
        send_byte(8'h11, k); chk("R5 data ack 0", 8'(k), 8'd1);
        send_byte(8'h22, k); chk("R5 data ack 1", 8'(k), 8'd1);
        send_byte(8'h33, k); chk("R5 data ack 2", 8'(k), 8'd1);
        bus_stop();
        exp_mem[5] = 8'h11; exp_mem[6] = 8'h22; exp_mem[7] = 8'h33;
        chk("R6 stored at 5", mem[5], exp_mem[5]);
        chk("R6 stored at 7", mem[7], exp_mem[7]);
    endtask

    task automatic t_random_read();
        logic k;
        logic [7:0] d;
        set_word(8'd5);
        bus_start();
        send_byte(8'hD1, k); chk("R10 read address after restart ack", 8'(k), 8'd1);
        recv_byte(1'b1, d);  chk("R7 read byte 5", d, exp_mem[5]);
        recv_byte(1'b1, d);  chk("R7 read byte 6", d, exp_mem[6]);
        recv_byte(1'b0, d);  chk("R7 read byte 7", d, exp_mem[7]);
        chk("R8 released after nack", 8'(sda_drive_low), 8'd0);
        recv_byte(1'b0, d);  chk("R8 no data after nack", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_current_read();
        logic k;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD1, k); chk("R9 current read ack", 8'(k), 8'd1);
        recv_byte(1'b0, d);  chk("R9 R8 pointer held at 7", d, exp_mem[7]);
        bus_stop();
    endtask

    task automatic t_wrap();
        logic k;
        logic [7:0] d;
        set_word(8'd62);
        send_byte(8'hA1, k); send_byte(8'hB2, k); send_byte(8'hC3, k);
        chk("R6 ack after wrap", 8'(k), 8'd1);
        bus_stop();
        exp_mem[62] = 8'hA1; exp_mem[63] = 8'hB2; exp_mem[0] = 8'hC3;
        set_word(8'd62);
        bus_start();
        send_byte(8'hD1, k);
        recv_byte(1'b1, d); chk("R6 wrap read 62", d, exp_mem[62]);
        recv_byte(1'b1, d); chk("R6 wrap read 63", d, exp_mem[63]);
        recv_byte(1'b1, d); chk("R6 wrap read 0", d, exp_mem[0]);
        recv_byte(1'b0, d); chk("R6 wrap read 1", d, exp_mem[1]);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic k;
        logic [7:0] d;
        bus_start();
        send_byte(8'hA0, k); chk("R4 foreign address nack", 8'(k), 8'd0);
        send_byte(8'h10, k); chk("R4 word ignored", 8'(k), 8'd0);
        send_byte(8'h99, k); chk("R4 data ignored", 8'(k), 8'd0);
        bus_stop();
        set_word(8'h10);
        bus_start();
        send_byte(8'hD1, k);
        recv_byte(1'b0, d); chk("R4 location untouched", d, exp_mem[16]);
        bus_stop();
    endtask

    task automatic t_stop();
        logic k;
        logic [7:0] d;
        set_word(8'h30);
        send_byte(8'h77, k);
        bus_stop();
        exp_mem[48] = 8'h77;
        send_byte(8'h88, k); chk("R2 byte after stop nack", 8'(k), 8'd0);
        set_word(8'h30);
        bus_start();
        send_byte(8'hD1, k);
        recv_byte(1'b1, d); chk("R2 written before stop", d, exp_mem[48]);
        recv_byte(1'b0, d); chk("R2 no write after stop", d, exp_mem[49]);
        bus_stop();
    endtask

    task automatic t_pwrfail();
        logic k;
        logic [7:0] d;
        set_word(8'h20);
        pwr_fail = 1'b1;
        wcyc(5);
        chk("R11 released on power fail", 8'(sda_drive_low), 8'd0);
        send_byte(8'h55, k); chk("R11 ignored under power fail", 8'(k), 8'd0);
        bus_stop();
        pwr_fail = 1'b0;
        wcyc(5);
        bus_start();
        send_byte(8'hD1, k); chk("R11 ack after power returns", 8'(k), 8'd1);
        recv_byte(1'b0, d);  chk("R11 pointer cleared", d, exp_mem[0]);
        bus_stop();
        set_word(8'h20);
        bus_start();
        send_byte(8'hD1, k);
        recv_byte(1'b0, d);  chk("R11 no write under power fail", d, exp_mem[32]);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) exp_mem[i] = pattern(i);
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; pwr_fail = 1'b0;
        wcyc(5);
        rst = 1'b0;
        wcyc(5);
        t_reset();
        t_write_burst();
        t_random_read();
        t_current_read();
        t_wrap();
        t_mismatch();
        t_stop();
        t_pwrfail();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule